// File: doc/BRIEF.md
# Switch Register Access Bridge

The bridge gives a host processor a small window of 32-bit registers through which it reaches a paged register file inside a switch. The host first claims ownership: it raises a request bit and waits until an outside arbiter returns grant. It then stages up to 64 bits of write data in two words and writes one command word. That word holds the page, the offset within the page, the direction and a go bit. Go stays set while the back-end access runs and drops when it ends, so the host polls it. A read result lands in two read-data words at the moment go drops.

The back-end side is a valid/acknowledge port with any latency. It carries page, offset, direction and 64-bit data. A reset bit in the command word abandons a stalled access. The block also latches event pulses from the switch into a write-one-to-clear capture register and raises a host interrupt when that register is non-zero and the interrupt is enabled. For 8-, 16- and 32-bit registers the host uses only the low data words. For 48-bit registers only the lower 16 bits of the high words count. The bridge moves all 64 bits in every case.

Top module: `sw_reg_bridge`

## Requirements
- R1: Control word at 0x40: bit 3 is the ownership request and drives own_req_o. Bit 1 is the interrupt enable. Both are read/write. Bit 4 reads own_gnt_i and bit 6 reads init_done_i. All other bits read 0.
- R2: A write to the command word at 0x2C that has go (bit 0) set and reset (bit 2) clear, made while grant is held and no access is running, starts one access. be_valid_o is high the cycle after the write. be_page_o is taken from bits 31:24, be_offset_o from bits 23:16 and be_write_o from bit 1. Command readback gives those fields, with bit 0 reading 1.
- R3: A command write made without grant, or while an access is running, is ignored. No access starts, and the back-end fields and the command readback keep their values.
- R4: be_valid_o and the access fields hold until be_ack_i is sampled high. Go reads 0 from the cycle after that acknowledge.
- R5: On a read access, be_rdata_i[31:0] goes to the word at 0x3C and be_rdata_i[63:32] to the word at 0x38. Both are taken at the same edge that clears go. A write access leaves both words unchanged.
- R6: The words at 0x34 (low) and 0x30 (high) are read/write, and be_wdata_o is {0x30 word, 0x34 word}.
- R7: A command write with bit 2 set drops be_valid_o and clears go at the next edge. It starts no access and leaves the staged write and read data words unchanged.
- R8: Each bit of evt_i sets the matching bit of the capture register at 0x44 (bits 12:0). Writing 1 to a bit clears it. An event that arrives in the same cycle as a clear of its bit stays set.
- R9: irq_o is high exactly when the interrupt enable is set and any capture bit is set.
- R10: Unmapped addresses read 0, and writes to the read-data words or to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_req_i | input | 1 | Host access strobe |
| hst_we_i | input | 1 | Host write when high, read when low |
| hst_addr_i | input | 8 | Host byte address |
| hst_wdata_i | input | 32 | Host write data |
| hst_rdata_o | output | 32 | Host read data, combinational from address |
| own_req_o | output | 1 | Ownership request to arbiter |
| own_gnt_i | input | 1 | Ownership grant from arbiter |
| init_done_i | input | 1 | Switch initialisation complete |
| be_valid_o | output | 1 | Back-end access valid |
| be_write_o | output | 1 | Back-end direction, 1 = write |
| be_page_o | output | 8 | Back-end page number |
| be_offset_o | output | 8 | Back-end register offset |
| be_wdata_o | output | 64 | Back-end write data |
| be_ack_i | input | 1 | Back-end acknowledge |
| be_rdata_i | input | 64 | Back-end read data, valid with acknowledge |
| evt_i | input | 13 | Event pulses from the switch |
| irq_o | output | 1 | Host interrupt |

## Verification
Host reads are combinational, so a register written at one edge is read back in the low phase that follows it. A command shows on the back end one edge after the write. Go clears, and read data appears, one edge after the acknowledge cycle. The bench records the cycle number at which its back-end model acknowledges. It then polls go every cycle and requires the first 0 to arrive exactly one cycle later, under random back-end latencies from zero to five. Captured events and the interrupt output are sampled one edge after the pulse or the clear.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int HW   = 32;
  localparam int PG_W = 8;
  localparam int DW   = 2 * HW;

  localparam logic [7:0] A_CMD = 8'h2C;
  localparam logic [7:0] A_WDH = 8'h30;
  localparam logic [7:0] A_WDL = 8'h34;
  localparam logic [7:0] A_RDH = 8'h38;
  localparam logic [7:0] A_RDL = 8'h3C;
  localparam logic [7:0] A_CTL = 8'h40;
  localparam logic [7:0] A_INT = 8'h44;

  localparam int C_GO   = 0;
  localparam int C_WR   = 1;
  localparam int C_RST  = 2;
  localparam int C_OFS  = 16;
  localparam int C_PAGE = 24;

  localparam int K_IEN  = 1;
  localparam int K_REQ  = 3;
  localparam int K_GNT  = 4;
  localparam int K_INIT = 6;

  typedef struct packed {
    logic [PG_W-1:0] page;
    logic [PG_W-1:0] ofs;
    logic            wr;
  } be_cmd_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic req_bit_i,
  input  logic ien_bit_i,
  output logic req_o,
  output logic ien_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      ien_o <= 1'b0;
    end else if (we_i) begin
      req_o <= req_bit_i;
      ien_o <= ien_bit_i;
    end
  end
endmodule

// File: rtl/brg_cmd.sv
module brg_cmd
  import brg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic            go_i,
  input  logic            abort_i,
  input  be_cmd_t         cmd_i,
  input  logic            gnt_i,
  input  logic            be_ack_i,
  input  logic [DW-1:0]   be_rdata_i,
  output logic            busy_o,
  output be_cmd_t         cmd_o,
  output logic [DW-1:0]   rdata_o
);
  logic abort, start, done;

  assign abort = cmd_we_i & abort_i;
  assign start = cmd_we_i & ~abort_i & go_i & gnt_i & ~busy_o;
  assign done  = busy_o & be_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cmd_o  <= '0;
    end else if (abort) begin
      busy_o <= 1'b0;
    end else if (start) begin
      busy_o <= 1'b1;
      cmd_o  <= cmd_i;
    end else if (done) begin
      busy_o <= 1'b0;
    end
  end

  // read result lands on the edge that clears busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rdata_o <= '0;
    else if (done && !abort && !cmd_o.wr) rdata_o <= be_rdata_i;
  end
endmodule

// File: rtl/brg_irq_cap.sv
module brg_irq_cap #(
  parameter int EVT_N = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_we_i,
  input  logic [EVT_N-1:0] clr_mask_i,
  input  logic [EVT_N-1:0] evt_i,
  input  logic             ien_i,
  output logic [EVT_N-1:0] cap_o,
  output logic             irq_o
);
  for (genvar b = 0; b < EVT_N; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cap_o[b] <= 1'b0;
      else         cap_o[b] <= (cap_o[b] & ~(clr_we_i & clr_mask_i[b])) | evt_i[b];
    end
  end

  assign irq_o = ien_i & (|cap_o);
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
  import brg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int EVT_N  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic [ADDR_W-1:0] hst_addr_i,
  input  logic [HW-1:0]     hst_wdata_i,
  output logic [HW-1:0]     hst_rdata_o,
  output logic              own_req_o,
  input  logic              own_gnt_i,
  input  logic              init_done_i,
  output logic              be_valid_o,
  output logic              be_write_o,
  output logic [PG_W-1:0]   be_page_o,
  output logic [PG_W-1:0]   be_offset_o,
  output logic [DW-1:0]     be_wdata_o,
  input  logic              be_ack_i,
  input  logic [DW-1:0]     be_rdata_i,
  input  logic [EVT_N-1:0]  evt_i,
  output logic              irq_o
);
  localparam int NWD = DW / HW;

  logic             hst_wr;
  logic             sel_cmd, sel_ctl, sel_int;
  logic             ien_q, busy_q;
  be_cmd_t          cmd_in, cmd_q;
  logic [DW-1:0]    rd_q;
  logic [EVT_N-1:0] cap_q;
  logic [NWD-1:0][HW-1:0] wd_q;

  assign hst_wr  = hst_req_i & hst_we_i;
  assign sel_cmd = hst_addr_i == ADDR_W'(A_CMD);
  assign sel_ctl = hst_addr_i == ADDR_W'(A_CTL);
  assign sel_int = hst_addr_i == ADDR_W'(A_INT);

  assign cmd_in.page = hst_wdata_i[C_PAGE +: PG_W];
  assign cmd_in.ofs  = hst_wdata_i[C_OFS  +: PG_W];
  assign cmd_in.wr   = hst_wdata_i[C_WR];

  brg_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (hst_wr & sel_ctl),
    .req_bit_i (hst_wdata_i[K_REQ]),
    .ien_bit_i (hst_wdata_i[K_IEN]),
    .req_o     (own_req_o),
    .ien_o     (ien_q)
  );

  brg_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (hst_wr & sel_cmd),
    .go_i       (hst_wdata_i[C_GO]),
    .abort_i    (hst_wdata_i[C_RST]),
    .cmd_i      (cmd_in),
    .gnt_i      (own_gnt_i),
    .be_ack_i   (be_ack_i),
    .be_rdata_i (be_rdata_i),
    .busy_o     (busy_q),
    .cmd_o      (cmd_q),
    .rdata_o    (rd_q)
  );

  brg_irq_cap #(.EVT_N(EVT_N)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_we_i   (hst_wr & sel_int),
    .clr_mask_i (hst_wdata_i[EVT_N-1:0]),
    .evt_i      (evt_i),
    .ien_i      (ien_q),
    .cap_o      (cap_q),
    .irq_o      (irq_o)
  );

  // staged write words: index 0 low, 1 high
  for (genvar w = 0; w < NWD; w++) begin : g_wd
    localparam logic [7:0] WA = (w == 0) ? A_WDL : A_WDH;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   wd_q[w] <= '0;
      else if (hst_wr && hst_addr_i == ADDR_W'(WA)) wd_q[w] <= hst_wdata_i;
    end
  end

  assign be_wdata_o  = wd_q;
  assign be_valid_o  = busy_q;
  assign be_write_o  = cmd_q.wr;
  assign be_page_o   = cmd_q.page;
  assign be_offset_o = cmd_q.ofs;

  always_comb begin
    hst_rdata_o = '0;
    unique case (1'b1)
      sel_cmd: begin
        hst_rdata_o[C_PAGE +: PG_W] = cmd_q.page;
        hst_rdata_o[C_OFS  +: PG_W] = cmd_q.ofs;
        hst_rdata_o[C_WR]           = cmd_q.wr;
        hst_rdata_o[C_GO]           = busy_q;
      end
      sel_ctl: begin
        hst_rdata_o[K_IEN]  = ien_q;
        hst_rdata_o[K_REQ]  = own_req_o;
        hst_rdata_o[K_GNT]  = own_gnt_i;
        hst_rdata_o[K_INIT] = init_done_i;
      end
      sel_int:                             hst_rdata_o = HW'(cap_q);
      (hst_addr_i == ADDR_W'(A_WDL)):      hst_rdata_o = wd_q[0];
      (hst_addr_i == ADDR_W'(A_WDH)):      hst_rdata_o = wd_q[1];
      (hst_addr_i == ADDR_W'(A_RDL)):      hst_rdata_o = rd_q[HW-1:0];
      (hst_addr_i == ADDR_W'(A_RDH)):      hst_rdata_o = rd_q[DW-1:HW];
      default:                             hst_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/brg_chk.sv
module brg_chk
  import brg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int EVT_N  = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hst_req_i,
  input logic              hst_we_i,
  input logic [ADDR_W-1:0] hst_addr_i,
  input logic              rst_bit_i,
  input logic              own_gnt_i,
  input logic              be_valid_o,
  input logic              be_ack_i,
  input logic              be_write_o,
  input logic [PG_W-1:0]   be_page_o,
  input logic [PG_W-1:0]   be_offset_o,
  input logic [EVT_N-1:0]  evt_i,
  input logic [EVT_N-1:0]  cap_i,
  input logic              irq_o
);
  logic abort_w, ctl_w;
  assign abort_w = hst_req_i && hst_we_i && hst_addr_i == ADDR_W'(A_CMD) && rst_bit_i;
  assign ctl_w   = hst_req_i && hst_we_i && hst_addr_i == ADDR_W'(A_CTL);

  AST_START_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(be_valid_o) |-> $past(own_gnt_i)); // R2

  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_valid_o && $past(be_valid_o)) |-> $stable({be_page_o, be_offset_o, be_write_o})); // R3

  AST_VALID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_valid_o && !be_ack_i && !abort_w) |=> be_valid_o); // R4

  AST_ACK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_valid_o && be_ack_i) |=> !be_valid_o); // R4

  AST_ABORT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_w |=> !be_valid_o); // R7

  AST_EVT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((cap_i & $past(evt_i)) == $past(evt_i))); // R8

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(evt_i != '0) || $past(ctl_w))); // R9
endmodule

bind sw_reg_bridge brg_chk #(.ADDR_W(ADDR_W), .EVT_N(EVT_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hst_req_i   (hst_req_i),
  .hst_we_i    (hst_we_i),
  .hst_addr_i  (hst_addr_i),
  .rst_bit_i   (hst_wdata_i[2]),
  .own_gnt_i   (own_gnt_i),
  .be_valid_o  (be_valid_o),
  .be_ack_i    (be_ack_i),
  .be_write_o  (be_write_o),
  .be_page_o   (be_page_o),
  .be_offset_o (be_offset_o),
  .evt_i       (evt_i),
  .cap_i       (cap_q),
  .irq_o       (irq_o)
);

// File: tb/sw_reg_bridge_tb_top.sv
module sw_reg_bridge_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hst_req_i = 1'b0, hst_we_i = 1'b0;
  logic [7:0]  hst_addr_i = '0;
  logic [31:0] hst_wdata_i = '0, hst_rdata_o;
  logic        own_req_o, own_gnt_i = 1'b0, init_done_i = 1'b0;
  logic        be_valid_o, be_write_o, be_ack_i = 1'b0;
  logic [7:0]  be_page_o, be_offset_o;
  logic [63:0] be_wdata_o, be_rdata_i = '0;
  logic [12:0] evt_i = '0;
  logic        irq_o;

  always #10 clk_i = ~clk_i;

  sw_reg_bridge dut_i (.*);

  int n_run = 0, n_fail = 0, cyc = 0;
  always @(posedge clk_i) cyc++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mdl(input logic [7:0] p, input logic [7:0] o);
    return {p, o, p ^ 8'h5A, o + 8'h11, ~p, ~o, p + o, 8'hC3};
  endfunction

  // back-end model
  int bk_lat = 0, bk_cnt = 0, bk_ack_cyc = 0;
  logic [7:0]  bk_page, bk_ofs;
  logic        bk_wr;
  logic [63:0] bk_wd;
  initial forever begin
    @(negedge clk_i);
    be_ack_i = 1'b0;
    if (be_valid_o) begin
      if (bk_cnt >= bk_lat) begin
        be_ack_i = 1'b1;
        be_rdata_i = mdl(be_page_o, be_offset_o);
        bk_page = be_page_o; bk_ofs = be_offset_o; bk_wr = be_write_o; bk_wd = be_wdata_o;
        bk_ack_cyc = cyc;
        bk_cnt = 0;
      end else bk_cnt++;
    end else bk_cnt = 0;
  end

  // arbiter model: grant trails request by two cycles
  logic gnt_d = 1'b0;
  initial forever begin
    @(negedge clk_i);
    own_gnt_i = gnt_d;
    gnt_d = own_req_o;
  end

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    hst_req_i = 1'b1; hst_we_i = 1'b1; hst_addr_i = a; hst_wdata_i = d;
    @(negedge clk_i);
    hst_req_i = 1'b0; hst_we_i = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    hst_addr_i = a;
    #1 d = hst_rdata_o;
  endtask

  task automatic poll(output int c);
    logic [31:0] v;
    c = -1;
    for (int k = 0; k < 2000; k++) begin
      hr(8'h2C, v);
      if (!v[0]) begin c = cyc; break; end
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v, rlo, rhi;
    logic [63:0] exp_rd;
    int c;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    hr(8'h2C, v);   chk("R2 reset cmd", v, 0);
    hr(8'h40, v);   chk("R1 reset ctl", v, 0);
    chk("R9 reset irq", irq_o, 0);
    chk("R4 reset valid", be_valid_o, 0);
    init_done_i = 1'b1;
    hr(8'h40, v);   chk("R1 init flag", v, 32'h40);

    // R3: command without grant
    hw(8'h2C, 32'h0102_0001);
    chk("R3 no grant valid", be_valid_o, 0);
    hr(8'h2C, v);   chk("R3 no grant cmd", v, 0);

    // R1: ownership
    hw(8'h40, 32'h8);
    chk("R1 req out", own_req_o, 1);
    repeat (4) @(negedge clk_i);
    hr(8'h40, v);   chk("R1 granted ctl", v, 32'h58);

    // R6: staging
    hw(8'h34, 32'hDEAD_BEEF);
    hw(8'h30, 32'h0BAD_F00D);
    chk("R6 be_wdata", be_wdata_o, 64'h0BAD_F00D_DEAD_BEEF);
    hr(8'h30, v);   chk("R6 wdh readback", v, 32'h0BAD_F00D);

    // R2 / R3 / R4 with a stalled back end
    bk_lat = 100000;
    hw(8'h2C, 32'h1234_0001);
    chk("R2 valid", be_valid_o, 1);
    chk("R2 fields", {be_page_o, be_offset_o, 7'd0, be_write_o}, {8'h12, 8'h34, 8'h00});
    hr(8'h2C, v);   chk("R2 go busy", v, 32'h1234_0001);
    hw(8'h2C, 32'h7756_0003);
    hr(8'h2C, v);   chk("R3 busy cmd ignored", v, 32'h1234_0001);
    chk("R3 busy page", be_page_o, 8'h12);
    repeat (5) @(negedge clk_i);
    chk("R4 valid held", be_valid_o, 1);

    // R7: abort
    hr(8'h3C, rlo);
    hw(8'h2C, 32'h0000_0004);
    chk("R7 valid dropped", be_valid_o, 0);
    hr(8'h2C, v);   chk("R7 go cleared", v[0], 0);
    hr(8'h34, v);   chk("R7 wdl kept", v, 32'hDEAD_BEEF);
    hr(8'h30, v);   chk("R7 wdh kept", v, 32'h0BAD_F00D);
    hr(8'h3C, v);   chk("R7 rdl kept", v, rlo);
    bk_lat = 0;

    // random accesses
    exp_rd = '0;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] p, o;
      logic wr;
      logic [63:0] d;
      p = 8'($urandom); o = 8'($urandom); wr = 1'($urandom);
      d = {$urandom, $urandom};
      bk_lat = $urandom % 6;
      if (wr) begin
        hw(8'h34, d[31:0]);
        hw(8'h30, d[63:32]);
        chk("R6 staged", be_wdata_o, d);
        hw(8'h2C, {p, o, 16'h0003});
      end else hw(8'h2C, {p, o, 16'h0001});
      poll(c);
      chk("R4 go clears one cycle after ack", c, bk_ack_cyc + 1);
      chk("R2 back-end fields", {bk_page, bk_ofs, bk_wr}, {p, o, wr});
      if (wr) chk("R2 back-end wdata", bk_wd, d);
      else exp_rd = mdl(p, o);
      hr(8'h3C, rlo); hr(8'h38, rhi);
      chk("R5 read data", {rhi, rlo}, exp_rd);
    end
    bk_lat = 0;

    // R10
    hr(8'h00, v);   chk("R10 unmapped", v, 0);
    hw(8'h3C, 32'hFFFF_FFFF);
    hr(8'h3C, v);   chk("R10 rdl read-only", v, exp_rd[31:0]);

    // R8 / R9
    @(negedge clk_i); evt_i = 13'h0008;
    @(negedge clk_i); evt_i = '0;
    hr(8'h44, v);   chk("R8 capture", v, 32'h8);
    chk("R9 irq disabled", irq_o, 0);
    hw(8'h40, 32'h0A);
    chk("R9 irq enabled", irq_o, 1);
    @(negedge clk_i);
    hst_req_i = 1; hst_we_i = 1; hst_addr_i = 8'h44; hst_wdata_i = 32'h8; evt_i = 13'h0208;
    @(negedge clk_i);
    hst_req_i = 0; hst_we_i = 0; evt_i = '0;
    hr(8'h44, v);   chk("R8 event beats clear", v, 32'h208);
    hw(8'h44, 32'h0000_0200);
    hr(8'h44, v);   chk("R8 single clear", v, 32'h8);
    @(negedge clk_i); evt_i = 13'h1000;
    @(negedge clk_i); evt_i = '0;
    hr(8'h44, v);   chk("R8 top bit", v, 32'h1008);
    hw(8'h44, 32'hFFFF_FFFF);
    hr(8'h44, v);   chk("R8 clear all", v, 0);
    chk("R9 irq off", irq_o, 0);

    // R1: release
    hw(8'h40, 32'h0);
    chk("R1 req released", own_req_o, 0);
    repeat (4) @(negedge clk_i);
    hr(8'h40, v);   chk("R1 grant dropped", v, 32'h40);

    summary();
  end
endmodule